// File: doc/BRIEF.md
# Serial Shift-Register Output Controller

This block drives an external chain of serial-in, parallel-out shift registers, giving up to 24 extra output pins in groups of eight. Software programs it through a small 32-bit register bus: two control words, a data word, a spare data word and an access word with a busy flag. A transfer serialises the output word onto a data line with a shift clock and then pulses a store strobe. The strobe makes the chain present the new word on its parallel pins.

Some of the lowest eight output bits can be handed to hardware. Two bits can follow a modem lane, and two groups of three bits can follow two PHY lanes. Each owned bit takes its lane value at the moment a transfer begins, and every other bit takes the CPU data. Transfers start either when software writes an update request or, in autonomous mode, from an internal timer at one of four low rates. The shift clock edge on which the chain samples is selectable.

Top module: `sro_ctrl`

## Requirements
- R1: After reset, control word A (offset 0x00) reads 0x8000_0000 and control word B (0x04), data (0x08), spare data (0x0C) and access (0x10) read 0. The shift clock idles high and the store strobe is low.
- R2: Control word A reads back bit 31 (software mode), bits 29:27, bit 26 and bits 25:24, with other bits 0. Control word B reads back bits 31:30, 24:23, 17:15 and 2:0, with other bits 0. Writes to the access word have no effect.
- R3: The transfer length is 8 times the position of the highest set bit of the group mask in control B bits 2:0 (001→8, 01x→16, 1xx→24). With a mask of 000 a request produces no strobe.
- R4: Bits go out most significant first, starting at bit length-1. The data line is stable whenever the shift clock moves to its sampling level.
- R5: For output bit i, a set bit in the ownership mask selects the lane value over CPU data. Control A bits 25:24 own bits 1:0 (modem lane), control A bits 29:27 own bits 4:2 (PHY A lane) and control B bits 17:15 own bits 7:5 (PHY B lane).
- R6: With control A bit 26 at 0 the shift clock idles high and the chain samples on its falling edge. With bit 26 at 1 it idles low and the chain samples on its rising edge. The setting is captured when a transfer starts.
- R7: After the last bit a store strobe of exactly one cycle is issued, once per transfer.
- R8: A write to control A with bit 31 set requests a transfer of the current data word.
- R9: Access word bit 0 reads 1 while a transfer is in progress. A request that arrives during a transfer is held, and it starts after the current transfer using the data present at that point.
- R10: With control A bit 31 at 0 and control B bits 31:30 equal to 2'b10, transfers repeat every CLK_HZ/f cycles. The rate field in control B bits 24:23 selects f: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 10.
- R11: In autonomous mode with control B bits 31:30 not equal to 2'b10, no transfer is started.
- R12: Reading the data word returns the value last written, whatever the ownership settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus / system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data (combinational from address) |
| modem_lane | input | 2 | hardware values for output bits 1:0 |
| phya_lane | input | 3 | hardware values for output bits 4:2 |
| phyb_lane | input | 3 | hardware values for output bits 7:5 |
| ser_data | output | 1 | serial data to the chain |
| ser_clk | output | 1 | shift clock to the chain |
| ser_latch | output | 1 | one-cycle store strobe |

## Verification
The assertions assume the hardware lanes may change at any time and that register writes come as single-cycle strobes. Nothing is assumed about when requests arrive relative to a transfer. The stimulus holds the lanes steady for a whole transfer, so the captured word can be predicted. It also makes its register accesses on the falling clock edge with one access per cycle. Rate and source changes are made only between measured timer intervals.

// File: rtl/sro_pkg.sv
package sro_pkg;

    localparam int GRP_N    = 3;
    localparam int GRP_BITS = 8;
    localparam int WORD     = GRP_N * GRP_BITS;
    localparam int LEN_W    = $clog2(WORD + 1);

    localparam logic [4:0] ADR_CTLA  = 5'h00;
    localparam logic [4:0] ADR_CTLB  = 5'h04;
    localparam logic [4:0] ADR_DATA  = 5'h08;
    localparam logic [4:0] ADR_SPARE = 5'h0C;
    localparam logic [4:0] ADR_ACC   = 5'h10;

    localparam logic [1:0] SRC_BUSCLK = 2'b10;

    typedef struct packed {
        logic       sw_mode;
        logic       rise_edge;
        logic [1:0] modem_own;
        logic [2:0] phya_own;
        logic [2:0] phyb_own;
        logic [1:0] src;
        logic [1:0] rate;
        logic [2:0] grp_en;
    } sro_cfg_t;

    localparam sro_cfg_t CFG_RESET = '{sw_mode: 1'b1, default: '0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_LATCH
    } sro_state_e;

    function automatic logic [LEN_W-1:0] shift_len(input logic [2:0] grp);
        if (grp[2])      return LEN_W'(3 * GRP_BITS);
        else if (grp[1]) return LEN_W'(2 * GRP_BITS);
        else if (grp[0]) return LEN_W'(GRP_BITS);
        else             return '0;
    endfunction

endpackage

// File: rtl/sro_regs.sv
module sro_regs
    import sro_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [4:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            busy,
    output sro_cfg_t        cfg,
    output logic [WORD-1:0] cpu_word,
    output logic            upd_req
);

    logic [31:0] data_q;
    logic [31:0] spare_q;
    logic        wr_a, wr_b;

    assign wr_a = bus_sel && bus_we && (bus_addr == ADR_CTLA);
    assign wr_b = bus_sel && bus_we && (bus_addr == ADR_CTLB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= CFG_RESET;
            data_q  <= '0;
            spare_q <= '0;
            upd_req <= 1'b0;
        end else begin
            upd_req <= wr_a && bus_wdata[31];
            if (wr_a) begin
                cfg.sw_mode   <= bus_wdata[31];
                cfg.phya_own  <= bus_wdata[29:27];
                cfg.rise_edge <= bus_wdata[26];
                cfg.modem_own <= bus_wdata[25:24];
            end
            if (wr_b) begin
                cfg.src      <= bus_wdata[31:30];
                cfg.rate     <= bus_wdata[24:23];
                cfg.phyb_own <= bus_wdata[17:15];
                cfg.grp_en   <= bus_wdata[2:0];
            end
            if (bus_sel && bus_we && (bus_addr == ADR_DATA))  data_q  <= bus_wdata;
            if (bus_sel && bus_we && (bus_addr == ADR_SPARE)) spare_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CTLA:  bus_rdata = {cfg.sw_mode, 1'b0, cfg.phya_own, cfg.rise_edge,
                                    cfg.modem_own, 24'b0};
            ADR_CTLB:  bus_rdata = {cfg.src, 5'b0, cfg.rate, 5'b0, cfg.phyb_own,
                                    12'b0, cfg.grp_en};
            ADR_DATA:  bus_rdata = data_q;
            ADR_SPARE: bus_rdata = spare_q;
            ADR_ACC:   bus_rdata = {31'b0, busy};
            default:   bus_rdata = '0;
        endcase
    end

    assign cpu_word = data_q[WORD-1:0];

endmodule

// File: rtl/sro_rate_timer.sv
module sro_rate_timer #(
    parameter int CLK_HZ = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int CW = $clog2(CLK_HZ / 2 + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;

    always_comb begin
        unique case (rate)
            2'b00: period = CW'(CLK_HZ / 2);
            2'b01: period = CW'(CLK_HZ / 4);
            2'b10: period = CW'(CLK_HZ / 8);
            default: period = CW'(CLK_HZ / 10);
        endcase
    end

    assign tick = enable && (cnt >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !enable || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sro_merge.sv
module sro_merge
    import sro_pkg::*;
(
    input  sro_cfg_t        cfg,
    input  logic [WORD-1:0] cpu_word,
    input  logic [1:0]      modem_lane,
    input  logic [2:0]      phya_lane,
    input  logic [2:0]      phyb_lane,
    output logic [WORD-1:0] out_word
);

    logic [GRP_BITS-1:0] own;
    logic [GRP_BITS-1:0] lane;

    assign own  = {cfg.phyb_own, cfg.phya_own, cfg.modem_own};
    assign lane = {phyb_lane, phya_lane, modem_lane};

    for (genvar i = 0; i < WORD; i++) begin : g_bit
        if (i < GRP_BITS) begin : g_shared
            assign out_word[i] = own[i] ? lane[i] : cpu_word[i];
        end else begin : g_cpu
            assign out_word[i] = cpu_word[i];
        end
    end

endmodule

// File: rtl/sro_shifter.sv
module sro_shifter
    import sro_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WORD-1:0]  word,
    input  logic [LEN_W-1:0] len,
    input  logic             rise_edge,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_latch,
    output logic             busy,
    output logic             clk_act
);

    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

    sro_state_e       state;
    logic             pend;
    logic             edge_q;
    logic [WORD-1:0]  shreg;
    logic [LEN_W-1:0] left;
    logic [DIV_W-1:0] div;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pend    <= 1'b0;
            edge_q  <= 1'b0;
            shreg   <= '0;
            left    <= '0;
            div     <= '0;
            clk_act <= 1'b0;
        end else begin
            pend <= pend | start;
            unique case (state)
                ST_IDLE: begin
                    pend <= 1'b0;
                    if ((start || pend) && (len != '0)) begin
                        shreg  <= word << (WORD - int'(len));
                        left   <= len;
                        div    <= '0;
                        edge_q <= rise_edge;
                        state  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (div == DIV_LAST) begin
                        div     <= '0;
                        clk_act <= 1'b1;
                        state   <= ST_TRAIL;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (div == DIV_LAST) begin
                        div     <= '0;
                        clk_act <= 1'b0;
                        if (left == LEN_W'(1)) begin
                            state <= ST_LATCH;
                        end else begin
                            shreg <= shreg << 1;
                            left  <= left - 1'b1;
                            state <= ST_LEAD;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ser_data  = shreg[WORD-1];
    assign ser_clk   = clk_act ^ ~edge_q;
    assign ser_latch = (state == ST_LATCH);
    assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/sro_ctrl.sv
module sro_ctrl
    import sro_pkg::*;
#(
    parameter int CLK_HZ   = 4000,
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  modem_lane,
    input  logic [2:0]  phya_lane,
    input  logic [2:0]  phyb_lane,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        ser_latch
);

    sro_cfg_t        cfg;
    logic [WORD-1:0] cpu_word;
    logic [WORD-1:0] merged;
    logic            upd_req;
    logic            tick;
    logic            busy_w;
    logic            clk_act_w;
    logic            auto_en;

    sro_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .cfg       (cfg),
        .cpu_word  (cpu_word),
        .upd_req   (upd_req)
    );

    assign auto_en = !cfg.sw_mode && (cfg.src == SRC_BUSCLK);

    sro_rate_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (auto_en),
        .rate   (cfg.rate),
        .tick   (tick)
    );

    sro_merge u_merge (
        .cfg        (cfg),
        .cpu_word   (cpu_word),
        .modem_lane (modem_lane),
        .phya_lane  (phya_lane),
        .phyb_lane  (phyb_lane),
        .out_word   (merged)
    );

    sro_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (upd_req || tick),
        .word      (merged),
        .len       (shift_len(cfg.grp_en)),
        .rise_edge (cfg.rise_edge),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_latch (ser_latch),
        .busy      (busy_w),
        .clk_act   (clk_act_w)
    );

endmodule

// File: rtl/sro_ctrl_chk.sv
module sro_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch,
    input logic busy,
    input logic clk_act
);

    // R7: store strobe lasts a single cycle
    assert_latch_single_R7: assert property (@(posedge clk) disable iff (rst)
        ser_latch |=> !ser_latch);

    // R7: store strobe only inside a transfer
    assert_latch_in_xfer_R7: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> busy);

    // R9: after the strobe the engine is idle for a cycle before a held request
    assert_idle_after_latch_R9: assert property (@(posedge clk) disable iff (rst)
        ser_latch |=> !busy);

    // R4: data line steady when the clock moves to its sampling level
    assert_data_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_act) |-> $stable(ser_data));

    // R6: shift clock holds its idle level between transfers
    assert_clk_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(ser_clk));

    // R6: no sampling level outside a transfer
    assert_no_active_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !clk_act);

endmodule

bind sro_ctrl sro_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch),
    .busy      (busy_w),
    .clk_act   (clk_act_w)
);

// File: tb/sro_ctrl_bench.sv
module sro_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  modem_lane = '0;
    logic [2:0]  phya_lane = '0;
    logic [2:0]  phyb_lane = '0;
    logic        ser_data, ser_clk, ser_latch;

    int nchk = 0;
    int nfail = 0;

    sro_ctrl #(.CLK_HZ(CLK_HZ), .SCK_HALF(2)) u_sro_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .modem_lane(modem_lane), .phya_lane(phya_lane), .phyb_lane(phyb_lane),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: collects bits on the sampling transition, records each strobe
    logic        mon_rise = 1'b0;
    logic        prev_clk = 1'b1;
    logic        prev_latch = 1'b0;
    logic        latch_double = 1'b0;
    logic [23:0] cap = '0;
    int          cap_n = 0;
    int          cyc = 0;
    int          lc = 0;
    logic [23:0] lw [0:15];
    int          ln [0:15];
    int          lt [0:15];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            cap = '0; cap_n = 0; prev_clk = ser_clk; prev_latch = 1'b0;
        end else begin
            if ((ser_clk !== prev_clk) && (ser_clk == mon_rise)) begin
                cap = {cap[22:0], ser_data};
                cap_n = cap_n + 1;
            end
            if (ser_latch && prev_latch) latch_double = 1'b1;
            if (ser_latch && !prev_latch) begin
                lw[lc % 16] = cap;
                ln[lc % 16] = cap_n;
                lt[lc % 16] = cyc;
                lc = lc + 1;
                cap = '0; cap_n = 0;
            end
            prev_clk = ser_clk;
            prev_latch = ser_latch;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_latch(input int target, input int limit, input string tag);
        int n = 0;
        while (lc < target && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " strobe seen"}, 32'(lc >= target), 32'd1);
    endtask

    function automatic logic [7:0] exp_merge(input logic [7:0] d, input logic [1:0] mo,
        input logic [1:0] ml, input logic [2:0] ao, input logic [2:0] al,
        input logic [2:0] bo, input logic [2:0] bl);
        logic [7:0] own = {bo, ao, mo};
        logic [7:0] ln8 = {bl, al, ml};
        for (int i = 0; i < 8; i++) exp_merge[i] = own[i] ? ln8[i] : d[i];
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 ctrl A reset", v, 32'h8000_0000);
        rd(5'h04, v); chk("R1 ctrl B reset", v, 32'h0);
        rd(5'h08, v); chk("R1 data reset", v, 32'h0);
        rd(5'h0C, v); chk("R1 spare reset", v, 32'h0);
        rd(5'h10, v); chk("R1 access reset", v, 32'h0);
        chk("R1 clock idle high", 32'(ser_clk), 32'd1);
        chk("R1 strobe low", 32'(ser_latch), 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); chk("R2 ctrl B fields", v, 32'hC183_8007);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'hDEAD_BEEF); rd(5'h08, v); chk("R12 data readback", v, 32'hDEAD_BEEF);
        wr(5'h0C, 32'h1234_5678); rd(5'h0C, v); chk("R2 spare readback", v, 32'h1234_5678);
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); chk("R2 access write ignored", v, 32'h0);
    endtask

    task automatic t_basic;
        int b = lc;
        mon_rise = 1'b0;
        wr(5'h04, 32'h0000_0001);
        wr(5'h08, 32'h0000_00B4);
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 1, 200, "R8");
        chk("R4 R8 8-bit word", 32'(lw[b % 16]), 32'h0000B4);
        chk("R3 8-bit length", 32'(ln[b % 16]), 32'd8);
        chk("R6 falling idle high", 32'(ser_clk), 32'd1);
    endtask

    task automatic t_len;
        int b;
        b = lc;
        wr(5'h04, 32'h0000_0003);
        wr(5'h08, 32'h00A1_3C96);
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 1, 300, "R3 16");
        chk("R3 16-bit length", 32'(ln[b % 16]), 32'd16);
        chk("R4 16-bit word", 32'(lw[b % 16]), 32'h003C96);
        b = lc;
        wr(5'h04, 32'h0000_0005);
        wr(5'h08, 32'h00F0_0F81);
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 1, 300, "R3 24");
        chk("R3 24-bit length", 32'(ln[b % 16]), 32'd24);
        chk("R4 24-bit word", 32'(lw[b % 16]), 32'hF00F81);
    endtask

    task automatic t_nogroup;
        int b;
        logic [31:0] v;
        wr(5'h04, 32'h0000_0000);
        b = lc;
        wr(5'h00, 32'h8000_0000);
        repeat (300) @(negedge clk);
        chk("R3 no group no strobe", 32'(lc), 32'(b));
        rd(5'h10, v); chk("R3 no group not busy", v, 32'h0);
    endtask

    task automatic t_merge;
        int b;
        logic [31:0] v;
        modem_lane = 2'b11; phya_lane = 3'b011; phyb_lane = 3'b111;
        wr(5'h04, 32'h0000_0001 | (32'(3'b011) << 15));
        wr(5'h08, 32'h0000_005C);
        b = lc;
        wr(5'h00, 32'h8000_0000 | (32'(3'b110) << 27) | (32'(2'b01) << 24));
        wait_latch(b + 1, 200, "R5");
        chk("R5 merged word", 32'(lw[b % 16]),
            32'(exp_merge(8'h5C, 2'b01, 2'b11, 3'b110, 3'b011, 3'b011, 3'b111)));
        rd(5'h08, v); chk("R12 raw data with ownership", v, 32'h0000_005C);
        modem_lane = 2'b00; phya_lane = 3'b000; phyb_lane = 3'b000;
        wr(5'h04, 32'h0000_0001);
    endtask

    task automatic t_rise;
        int b = lc;
        mon_rise = 1'b1;
        wr(5'h08, 32'h0000_0069);
        wr(5'h00, 32'h8400_0000);
        wait_latch(b + 1, 200, "R6 rise");
        chk("R6 rising-edge word", 32'(lw[b % 16]), 32'h000069);
        chk("R6 rising idle low", 32'(ser_clk), 32'd0);
        b = lc;
        mon_rise = 1'b0;
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 1, 200, "R6 fall");
        chk("R6 back to falling word", 32'(lw[b % 16]), 32'h000069);
        chk("R6 falling idle high again", 32'(ser_clk), 32'd1);
    endtask

    task automatic t_pending;
        int b = lc;
        logic [31:0] v;
        wr(5'h04, 32'h0000_0004);
        wr(5'h08, 32'h00C3_A55A);
        wr(5'h00, 32'h8000_0000);
        repeat (5) @(negedge clk);
        rd(5'h10, v); chk("R9 busy during transfer", v, 32'h1);
        wr(5'h08, 32'h0017_E881);
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 2, 400, "R9");
        chk("R9 first word", 32'(lw[b % 16]), 32'hC3A55A);
        chk("R9 held request new data", 32'(lw[(b + 1) % 16]), 32'h17E881);
        repeat (2) @(negedge clk);
        rd(5'h10, v); chk("R9 idle after both", v, 32'h0);
    endtask

    task automatic t_auto;
        int b;
        wr(5'h04, 32'h8180_0001);
        wr(5'h08, 32'h0000_0033);
        wr(5'h00, 32'h0000_0000);
        b = lc;
        wait_latch(b + 3, 2000, "R10 10Hz");
        chk("R10 period rate 11", 32'(lt[(b + 2) % 16] - lt[(b + 1) % 16]), 32'(CLK_HZ / 10));
        chk("R10 auto word", 32'(lw[(b + 2) % 16]), 32'h000033);
        wr(5'h04, 32'h8000_0001);
        b = lc;
        wait_latch(b + 3, 8000, "R10 2Hz");
        chk("R10 period rate 00", 32'(lt[(b + 2) % 16] - lt[(b + 1) % 16]), 32'(CLK_HZ / 2));
    endtask

    task automatic t_src;
        int b;
        wr(5'h04, 32'h4180_0001);
        repeat (60) @(negedge clk);
        b = lc;
        repeat (2500) @(negedge clk);
        chk("R11 other source no strobe", 32'(lc), 32'(b));
        wr(5'h00, 32'h8000_0000);
        wait_latch(b + 1, 200, "R8 after auto");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_basic();
        t_len();
        t_nogroup();
        t_merge();
        t_rise();
        t_pending();
        t_auto();
        t_src();
        chk("R7 strobe one cycle", 32'(latch_double), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule